// File: doc/BRIEF.md
# Programmable-Length Dual-Lane Delay Line

This block delays two 4-bit data lanes by a programmable number of clock cycles. Both lanes share one clock and one set of controls. Each lane pushes its input into a serial chain of seventeen pipeline stages on every rising edge. A selector copies one stage of that chain, from the second stage to the last, into a final output register. The total delay therefore runs from 3 to 18 cycles and equals the length code plus three.

The length code and a lane-mode bit go into a control register on each rising edge. Only the registered values steer the selectors. The control register has two states. In the TRACK state both lanes follow the length code. In the PINNED state the upper lane is held at the longest delay, 18 cycles, and the lower lane still follows the code. The control register moves from TRACK to PINNED on any edge that samples the mode bit at 1, and from PINNED back to TRACK on any edge that samples it at 0. A synchronous reset returns it to TRACK with code 0.

Retuning the delay never flushes the chain. Data already in flight shows up at the new delay, starting with the output register load that follows the capturing edge. Typical uses are aligning pipelines of different depth and compensating a variable latency in a signal path.

Top module: `dual_lane_delay`

## Requirements
- R1: In TRACK mode (mode pin 0), the lower lane output `dout[3:0]` after edge m equals `din[3:0]` as sampled at edge m-(c+2), where c is the registered length code. With code c the delay is c+3 cycles.
- R2: In TRACK mode the upper lane `dout[7:4]` follows `din[7:4]` with the same code-controlled delay as the lower lane.
- R3: In PINNED mode (mode pin 1), the upper lane delays `din[7:4]` by 18 cycles whatever the length code is.
- R4: In PINNED mode the lower lane keeps following the length code, as in R1.
- R5: The length code and the mode pin take effect through a control register. A new value sampled at edge e first changes the selected stage for the output load at edge e+1.
- R6: A change of code or mode leaves the seventeen chain stages of both lanes untouched. Data in flight emerges at the new delay, with no flush and no lost chain data.
- R7: A synchronous active-high `rst` clears the control register to code 0 in TRACK mode and clears every data register, whatever the other inputs are. The outputs read zero until new data has propagated.
- R8: Code 0 gives the shortest path of 3 cycles (first stage, second stage, output register). Code 15 gives the longest path of 18 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Lane data in; [3:0] lower lane, [7:4] upper lane |
| len_code | input | 4 | Length code; delay = code + 3 cycles |
| pin_hi | input | 1 | 1 pins the upper lane at 18 cycles, 0 lets it track |
| dout | output | 8 | Delayed lane data; [3:0] lower lane, [7:4] upper lane |

## Verification
The embedded properties assume that `rst` is asserted during the first clock edge. Until then, the selector and output registers hold undefined values, and the properties are disabled while `rst` is high. They also assume that `len_code` and `pin_hi` are always driven to known levels. The stimulus holds reset for the opening edges and drives every control input from a fixed-seed generator or from directed values, never leaving one floating. Random values on the data and control inputs during a mid-run reset test the claim that reset overrides them.

// File: rtl/dly_pkg.sv
package dly_pkg;

    localparam int CODE_W   = 4;
    localparam int TAP_BASE = 1;

    typedef enum logic {
        MODE_TRACK  = 1'b0,
        MODE_PINNED = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] len;
        lane_mode_e        mode;
    } ctrl_t;

endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
    import dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] len_code,
    input  logic              pin_hi,
    output ctrl_t             ctrl_q
);

    lane_mode_e mode_next;

    always_comb begin
        unique case (pin_hi)
            1'b0:    mode_next = MODE_TRACK;
            1'b1:    mode_next = MODE_PINNED;
            default: mode_next = MODE_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.len  <= '0;
            ctrl_q.mode <= MODE_TRACK;
        end else begin
            ctrl_q.len  <= len_code;
            ctrl_q.mode <= mode_next;
        end
    end

    p_ctrl_clear_r7: assert property (@(posedge clk)
        rst |=> (ctrl_q.len == '0 && ctrl_q.mode == MODE_TRACK))
        else $error("control register not cleared by reset");

endmodule

// File: rtl/dly_lane.sv
module dly_lane #(
    parameter int W     = 4,
    parameter int DEPTH = 17,
    parameter int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);

    logic [W-1:0] stage [DEPTH];
    logic [W-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    always_comb begin
        tap = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (sel == SEL_W'(i)) tap = stage[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= tap;
    end

    p_tap_range_r1: assert property (@(posedge clk) disable iff (rst)
        (sel >= SEL_W'(1) && sel <= SEL_W'(DEPTH-1)))
        else $error("tap select outside second..last stage");

    p_out_clear_r7: assert property (@(posedge clk)
        rst |=> (dout == '0))
        else $error("lane output not cleared by reset");

endmodule

// File: rtl/dual_lane_delay.sv
module dual_lane_delay
    import dly_pkg::*;
#(
    parameter int            LANE_W   = 4,
    parameter int            LANES    = 2,
    parameter logic [LANES-1:0] PIN_MASK = 2'b10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [CODE_W-1:0]       len_code,
    input  logic                    pin_hi,
    output logic [LANES*LANE_W-1:0] dout
);

    localparam int DEPTH    = (1 << CODE_W) + TAP_BASE;
    localparam int SEL_W    = $clog2(DEPTH);
    localparam int LAST_TAP = DEPTH - 1;

    ctrl_t ctrl_q;

    dly_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .len_code (len_code),
        .pin_hi   (pin_hi),
        .ctrl_q   (ctrl_q)
    );

    logic [SEL_W-1:0] sel [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (PIN_MASK[l]) begin : g_pinnable
            always_comb begin
                unique case (ctrl_q.mode)
                    MODE_PINNED: sel[l] = SEL_W'(LAST_TAP);
                    MODE_TRACK:  sel[l] = SEL_W'(ctrl_q.len) + SEL_W'(TAP_BASE);
                    default:     sel[l] = SEL_W'(TAP_BASE);
                endcase
            end

            p_pinned_tap_r3: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q.mode == MODE_PINNED) |-> (sel[l] == SEL_W'(LAST_TAP)))
                else $error("pinned lane not at last stage");
        end else begin : g_tracking
            always_comb sel[l] = SEL_W'(ctrl_q.len) + SEL_W'(TAP_BASE);
        end

        dly_lane #(
            .W     (LANE_W),
            .DEPTH (DEPTH),
            .SEL_W (SEL_W)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .din  (din[l*LANE_W +: LANE_W]),
            .sel  (sel[l]),
            .dout (dout[l*LANE_W +: LANE_W])
        );
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 && $stable(len_code) && $stable(ctrl_q.len) |=> $stable(sel[0]))
        else $error("lower tap moved with steady code");

endmodule

// File: tb/sim_dual_lane_delay.sv
`timescale 1ns/1ps
module sim_dual_lane_delay;

    localparam int NMAX = 4096;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic [3:0] len_code;
    logic       pin_hi;
    logic [7:0] dout;

    dual_lane_delay u0 (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .len_code (len_code),
        .pin_hi   (pin_hi),
        .dout     (dout)
    );

    always #2 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    int   edges = 0;
    logic [7:0] h_d   [NMAX];
    logic [3:0] h_c   [NMAX];
    logic       h_m   [NMAX];
    logic       h_r   [NMAX];
    int         h_lr  [NMAX];

    function automatic logic [3:0] lane_exp(int m, int k, int lane);
        int idx;
        if (h_r[m]) return 4'h0;
        idx = m - k;
        if (idx < 0 || idx <= h_lr[m-1]) return 4'h0;
        return lane ? h_d[idx][7:4] : h_d[idx][3:0];
    endfunction

    function automatic int eff_code(int m);
        if (m < 1 || h_r[m-1]) return 0;
        return int'(h_c[m-1]);
    endfunction

    function automatic int eff_mode(int m);
        if (m < 1 || h_r[m-1]) return 0;
        return int'(h_m[m-1]);
    endfunction

    function automatic string pick_tag(int m, int lane);
        int c = eff_code(m);
        int md = eff_mode(m);
        if (h_r[m] || (m >= 1 && h_r[m-1])) return "R7";
        if (m >= 2 && !h_r[m-2] && (h_c[m-1] != h_c[m-2] || h_m[m-1] != h_m[m-2])) return "R5";
        for (int j = 2; j <= 18; j++) begin
            if (m - j >= 1 && !h_r[m-j] && (h_c[m-j] != h_c[m-1] || h_m[m-j] != h_m[m-1]))
                return "R6";
        end
        if (lane == 1 && md == 1) return "R3";
        if (c == 0 || c == 15) return "R8";
        if (lane == 1) return "R2";
        return md ? "R4" : "R1";
    endfunction

    task automatic check_edge(int m);
        int c = eff_code(m);
        int md = eff_mode(m);
        logic [3:0] exp_lo = lane_exp(m, c + 2, 0);
        logic [3:0] exp_hi = lane_exp(m, md ? 17 : c + 2, 1);
        n_chk++;
        if (dout[3:0] !== exp_lo) begin
            n_bad++;
            $display("FAIL %s lower lane edge %0d: got %h expected %h", pick_tag(m, 0), m, dout[3:0], exp_lo);
        end
        n_chk++;
        if (dout[7:4] !== exp_hi) begin
            n_bad++;
            $display("FAIL %s upper lane edge %0d: got %h expected %h", pick_tag(m, 1), m, dout[7:4], exp_hi);
        end
    endtask

    task automatic tick(logic r, logic [7:0] d, logic [3:0] c, logic m);
        @(negedge clk);
        if (edges > 0) check_edge(edges - 1);
        rst = r; din = d; len_code = c; pin_hi = m;
        h_r[edges] = r; h_d[edges] = d; h_c[edges] = c; h_m[edges] = m;
        h_lr[edges] = r ? edges : ((edges > 0) ? h_lr[edges-1] : -1);
        @(posedge clk);
        edges++;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 4; i++) tick(1'b1, 8'h00, 4'h0, 1'b0);
        // R7: outputs zero right after reset
        tick(1'b0, 8'h00, 4'h0, 1'b0);
        // R8: impulse through the shortest and longest paths
        tick(1'b0, 8'hA5, 4'h0, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b0, 8'h00, 4'h0, 1'b0);
        tick(1'b0, 8'h3C, 4'hF, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b0, 8'h00, 4'hF, 1'b0);
        // R1 R2 R3 R4: sweep every code in both modes
        for (int md = 0; md < 2; md++) begin
            for (int c = 0; c < 16; c++) begin
                for (int i = 0; i < 24; i++) tick(1'b0, 8'($urandom), 4'(c), md[0]);
            end
        end
        // R5 R6: long delay in flight, then cut to shortest
        for (int i = 0; i < 10; i++) tick(1'b0, 8'($urandom), 4'hF, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b0, 8'($urandom), 4'h0, 1'b1);
        // R7: mid-run reset with random controls and data
        for (int i = 0; i < 2; i++) tick(1'b1, 8'($urandom), 4'($urandom), 1'($urandom));
        for (int i = 0; i < 20; i++) tick(1'b0, 8'($urandom), 4'h9, 1'b0);
        // R5 R6: random retuning while data is in flight
        for (int blk = 0; blk < 500; blk++) begin
            logic [3:0] c = 4'($urandom);
            logic m = 1'($urandom);
            int len = 1 + int'($urandom % 6);
            for (int i = 0; i < len; i++) tick(1'b0, 8'($urandom), c, m);
        end
        tick(1'b0, 8'h00, 4'h0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule